// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts processor events in two 32-bit counters that software can read and write through a small register port. A mode control register chooses, for each counter, which of eight single-cycle event inputs it counts. The same register chooses which of four time-base bits to watch and which interrupt conditions are armed.

The monitor raises an interrupt request level in two cases. The first is when either counter turns negative, meaning its most significant bit becomes 1. The second is when the watched time-base bit changes value. When the request is first raised, hardware freezes both counters so that software reads a stable snapshot. At the same moment, two sample registers record the instruction address and the data address presented on the inputs. The request, the freeze and the samples hold until software acknowledges the event by writing a one to the pending bit.

Register map: address 0 is the control register, 1 is counter 0, 2 is counter 1, 3 is the sampled instruction address and 4 is the sampled data address. The read data is registered: it shows the register selected by `reg_addr` one clock after the address is presented.

Top module: `pmon_top`

## Requirements
- R1: Addresses 1 and 2 hold counter 0 and counter 1, 32 bits each. A write stores `reg_wdata` exactly, and takes precedence over counting in the same cycle. `reg_rdata` shows the register at `reg_addr` one cycle later. Addresses 3 and 4 read the two sample registers, and any other address reads zero.
- R2: Control bits [2:0] select the event input for counter 0 and bits [5:3] select it for counter 1. While the counters are not frozen, each counter adds one in every cycle in which its selected `evt_i` bit is high. Unselected event inputs have no effect.
- R3: With the negative-enable bit (control bit 8) set and no interrupt pending, bit 31 of either counter being 1 sets the pending flag at the next clock edge. `irq_o` is the pending flag.
- R4: Control bits [7:6] pick the watched time-base bit at position 4*sel, giving positions 0, 4, 8 or 12. With the time-base enable bit (control bit 9) set, the pending flag is set at the edge on which that bit of `tb_i` differs from its value at the previous edge. Changes on other time-base bits have no effect.
- R5: With both enable bits clear, neither a negative counter nor a time-base change raises `irq_o`.
- R6: Control bit 10 is the freeze bit. While it is set, the counters do not count. Hardware sets it in the same edge that raises the pending flag. Software may write it to any value.
- R7: The pending flag (control bit 11, read back as 1 while pending) stays set until a control write with bit 11 equal to 1 clears it. A control write with bit 11 equal to 0 leaves it set.
- R8: In the edge that sets the pending flag, the sample registers load `iaddr_i` and `daddr_i`. While the flag is set, they do not change.
- R9: After reset, all registers read zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Per-cycle event pulses |
| tb_i | input | 64 | Free-running time-base value |
| iaddr_i | input | 32 | Current instruction address |
| daddr_i | input | 32 | Current data address |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Monitor interrupt request level |

## Verification
The assertions assume that a counter changes only through counting or a direct write to its own address. They also assume that the pending flag falls only when a control write carries a one in bit 11. No assumption is placed on how often events or time-base changes arrive. The stimulus leaves event inputs low during register reads, so that each expected count is fixed when it is queued. It clears a negative counter before acknowledging, so that the next expected interrupt level is fixed as well. Time-base changes are driven one bit at a time, so that each can be tied to a single watched position.

// File: rtl/pmon_pkg.sv
`timescale 1ns/1ps
package pmon_pkg;

  // Control register, bit 11 down to bit 0
  typedef struct packed {
    logic       pending;  // 11
    logic       freeze;   // 10
    logic       tb_en;    // 9
    logic       neg_en;   // 8
    logic [1:0] tb_sel;   // 7:6
    logic [2:0] sel1;     // 5:3
    logic [2:0] sel0;     // 2:0
  } pmon_ctrl_t;

  localparam int CTRL_W = $bits(pmon_ctrl_t);

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_CNT0 = 3'd1;
  localparam logic [2:0] RA_CNT1 = 3'd2;
  localparam logic [2:0] RA_SIA  = 3'd3;
  localparam logic [2:0] RA_SDA  = 3'd4;

endpackage

// File: rtl/pmon_counter.sv
`timescale 1ns/1ps
module pmon_counter #(
  parameter int W       = 32,
  parameter int NUM_EVT = 8,
  localparam int SEL_W  = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [SEL_W-1:0]   sel,
  input  logic               freeze,
  input  logic               wr,
  input  logic [W-1:0]       wdata,
  output logic [W-1:0]       cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr) begin
      cnt <= wdata;
    end else if (!freeze && evt[sel]) begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/pmon_tbflip.sv
`timescale 1ns/1ps
module pmon_tbflip #(
  parameter int TB_W      = 64,
  parameter int TB_STRIDE = 4,
  parameter int NSEL      = 4,
  localparam int SEL_W    = $clog2(NSEL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TB_W-1:0]  tb,
  input  logic [SEL_W-1:0] sel,
  output logic             flip
);

  logic [NSEL-1:0] tap;
  logic [NSEL-1:0] prev_q;
  logic            unused_tb;

  for (genvar k = 0; k < NSEL; k++) begin : g_tap
    assign tap[k] = tb[k*TB_STRIDE];
  end

  assign unused_tb = ^tb;

  // Keep history of every tap so that a new selection never sees a stale bit
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= tap;
  end

  assign flip = tap[sel] ^ prev_q[sel];

endmodule

// File: rtl/pmon_sampler.sv
`timescale 1ns/1ps
module pmon_sampler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] iaddr,
  input  logic [W-1:0] daddr,
  output logic [W-1:0] sia,
  output logic [W-1:0] sda
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sia <= '0;
      sda <= '0;
    end else if (capture) begin
      sia <= iaddr;
      sda <= daddr;
    end
  end

endmodule

// File: rtl/pmon_top.sv
`timescale 1ns/1ps
module pmon_top
  import pmon_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_EVT   = 8,
  parameter int TB_W      = 64,
  parameter int TB_STRIDE = 4,
  parameter int NUM_CNT   = 2,
  localparam int SEL_W    = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [TB_W-1:0]    tb_i,
  input  logic [DATA_W-1:0]  iaddr_i,
  input  logic [DATA_W-1:0]  daddr_i,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);

  pmon_ctrl_t         ctrl_q;
  pmon_ctrl_t         ctrl_w;
  logic               wr_ctrl;
  logic               clr_pend;
  logic               tb_flip;
  logic               any_neg;
  logic               trig;
  logic               raise;
  logic               frz;
  logic [DATA_W-1:0]  cnt_q  [NUM_CNT];
  logic [NUM_CNT-1:0] wr_cnt;
  logic [NUM_CNT-1:0] neg_vec;
  logic [SEL_W-1:0]   sel_arr [NUM_CNT];
  logic [DATA_W-1:0]  samp_i;
  logic [DATA_W-1:0]  samp_d;
  logic [DATA_W-1:0]  cnt0;
  logic [DATA_W-1:0]  cnt1;
  logic               wr_cnt0;
  logic               wr_cnt1;

  assign ctrl_w   = reg_wdata[CTRL_W-1:0];
  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign clr_pend = wr_ctrl && ctrl_w.pending;
  assign frz      = ctrl_q.freeze;

  assign sel_arr[0] = ctrl_q.sel0;
  assign sel_arr[1] = ctrl_q.sel1;

  // Counter bank
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign wr_cnt[i]  = reg_we && (reg_addr == RA_CNT0 + 3'(i));
    assign neg_vec[i] = cnt_q[i][DATA_W-1];

    pmon_counter #(.W(DATA_W), .NUM_EVT(NUM_EVT)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt_i),
      .sel    (sel_arr[i]),
      .freeze (frz),
      .wr     (wr_cnt[i]),
      .wdata  (reg_wdata),
      .cnt    (cnt_q[i])
    );
  end

  assign cnt0    = cnt_q[0];
  assign cnt1    = cnt_q[1];
  assign wr_cnt0 = wr_cnt[0];
  assign wr_cnt1 = wr_cnt[1];
  assign any_neg = |neg_vec;

  pmon_tbflip #(.TB_W(TB_W), .TB_STRIDE(TB_STRIDE), .NSEL(4)) u_tb (
    .clk  (clk),
    .rst  (rst),
    .tb   (tb_i),
    .sel  (ctrl_q.tb_sel),
    .flip (tb_flip)
  );

  assign trig  = (ctrl_q.neg_en && any_neg) || (ctrl_q.tb_en && tb_flip);
  assign raise = trig && !ctrl_q.pending;

  // Control register: software fields, then hardware set overrides
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.sel0   <= ctrl_w.sel0;
        ctrl_q.sel1   <= ctrl_w.sel1;
        ctrl_q.tb_sel <= ctrl_w.tb_sel;
        ctrl_q.neg_en <= ctrl_w.neg_en;
        ctrl_q.tb_en  <= ctrl_w.tb_en;
        ctrl_q.freeze <= ctrl_w.freeze;
      end
      if (clr_pend) ctrl_q.pending <= 1'b0;
      if (raise) begin
        ctrl_q.pending <= 1'b1;
        ctrl_q.freeze  <= 1'b1;
      end
    end
  end

  pmon_sampler #(.W(DATA_W)) u_samp (
    .clk     (clk),
    .rst     (rst),
    .capture (raise),
    .iaddr   (iaddr_i),
    .daddr   (daddr_i),
    .sia     (samp_i),
    .sda     (samp_d)
  );

  // Registered readback
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= DATA_W'(ctrl_q);
        RA_CNT0: reg_rdata <= cnt0;
        RA_CNT1: reg_rdata <= cnt1;
        RA_SIA:  reg_rdata <= samp_i;
        RA_SDA:  reg_rdata <= samp_d;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign irq_o = ctrl_q.pending;

endmodule

// File: rtl/pmon_chk.sv
`timescale 1ns/1ps
module pmon_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              freeze,
  input logic              neg_en,
  input logic              tb_en,
  input logic              clr,
  input logic              wr0,
  input logic              wr1,
  input logic [DATA_W-1:0] cnt0,
  input logic [DATA_W-1:0] cnt1,
  input logic [DATA_W-1:0] sia,
  input logic [DATA_W-1:0] sda
);

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !clr |=> irq);

  // R6
  frz_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> freeze);

  // R6
  frz_cnt0_chk: assert property (@(posedge clk) disable iff (rst)
    freeze && !wr0 |=> $stable(cnt0));

  // R6
  frz_cnt1_chk: assert property (@(posedge clk) disable iff (rst)
    freeze && !wr1 |=> $stable(cnt1));

  // R8
  samp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> ($stable(sia) && $stable(sda)));

  // R5
  no_src_chk: assert property (@(posedge clk) disable iff (rst)
    !irq && !neg_en && !tb_en |=> !irq);

  // R3
  neg_raise_chk: assert property (@(posedge clk) disable iff (rst)
    neg_en && !irq && (cnt0[DATA_W-1] || cnt1[DATA_W-1]) |=> irq);

endmodule

bind pmon_top pmon_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq_o),
  .freeze (frz),
  .neg_en (ctrl_q.neg_en),
  .tb_en  (ctrl_q.tb_en),
  .clr    (clr_pend),
  .wr0    (wr_cnt0),
  .wr1    (wr_cnt1),
  .cnt0   (cnt0),
  .cnt1   (cnt1),
  .sia    (samp_i),
  .sda    (samp_d)
);

// File: tb/pmon_top_test.sv
`timescale 1ns/1ps
module pmon_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_i = '0;
  logic [63:0] tb_i = '0;
  logic [31:0] iaddr_i = '0;
  logic [31:0] daddr_i = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       req_q [$];

  always #4 clk = ~clk;

  pmon_top uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .tb_i(tb_i),
    .iaddr_i(iaddr_i), .daddr_i(daddr_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Driver: present address and queue the expected read value
  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk);
    evt_i[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  task automatic chk_irq(input logic e, input string req);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq_o actual=%b expected=%b", req, irq_o, e);
    end
  endtask

  // Monitor: one edge after the address, compare the registered read data
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        #2;
        checks++;
        if (reg_rdata !== exp_q[0]) begin
          errors++;
          $display("FAIL %s rdata actual=%h expected=%h", req_q[0], reg_rdata, exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(req_q.pop_front());
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk_irq(1'b0, "R9");
    checks++;
    if (reg_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R9 rdata actual=%h expected=0", reg_rdata);
    end
    rd(3'd0, 32'h0, "R9");
    rd(3'd1, 32'h0, "R9");
    rd(3'd4, 32'h0, "R9");

    // R1 write/readback, unmapped address
    wr(3'd2, 32'h1234_5678);
    rd(3'd2, 32'h1234_5678, "R1");
    rd(3'd7, 32'h0, "R1");

    // R2 event selection: sel0=2, sel1=5
    wr(3'd0, 32'h0000_002A);
    pulse(2, 3);
    pulse(5, 2);
    pulse(0, 4);
    rd(3'd1, 32'h3, "R2");
    rd(3'd2, 32'h1234_567A, "R2");

    // R3 counter 0 crosses into negative
    wr(3'd1, 32'h7FFF_FFFE);
    wr(3'd0, 32'h0000_012A);
    pulse(2, 2);
    chk_irq(1'b0, "R3");
    iaddr_i = 32'h0000_A0A0; daddr_i = 32'h0000_B0B0;
    @(negedge clk);
    chk_irq(1'b1, "R3");
    iaddr_i = 32'h0000_FFFF; daddr_i = 32'h0000_EEEE;
    rd(3'd3, 32'h0000_A0A0, "R8");
    rd(3'd4, 32'h0000_B0B0, "R8");
    rd(3'd0, 32'h0000_0D2A, "R6");

    // R6 hardware freeze holds both counters
    pulse(2, 3);
    pulse(5, 2);
    rd(3'd1, 32'h8000_0000, "R6");
    rd(3'd2, 32'h1234_567A, "R6");

    // R7 write without the clear bit keeps the request
    wr(3'd0, 32'h0000_052A);
    chk_irq(1'b1, "R7");
    rd(3'd0, 32'h0000_0D2A, "R7");
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0000_092A);
    chk_irq(1'b0, "R7");
    @(negedge clk);
    chk_irq(1'b0, "R7");
    rd(3'd0, 32'h0000_012A, "R7");
    pulse(2, 1);
    rd(3'd1, 32'h1, "R6");

    // R4 time-base bit 8 watched (tb_sel=2)
    wr(3'd0, 32'h0000_02AA);
    @(negedge clk);
    tb_i = 64'h10;
    @(negedge clk);
    chk_irq(1'b0, "R4");
    tb_i = 64'h110; iaddr_i = 32'h0000_5555; daddr_i = 32'h0000_6666;
    @(negedge clk);
    chk_irq(1'b1, "R4");
    iaddr_i = 32'h0; daddr_i = 32'h0;
    rd(3'd3, 32'h0000_5555, "R8");
    rd(3'd4, 32'h0000_6666, "R8");
    wr(3'd0, 32'h0000_0AAA);
    chk_irq(1'b0, "R7");

    // R5 both enables off
    wr(3'd0, 32'h0);
    @(negedge clk);
    tb_i = 64'h10;
    wr(3'd2, 32'h8000_0000);
    @(negedge clk);
    chk_irq(1'b0, "R5");
    iaddr_i = 32'h0000_7777;
    wr(3'd0, 32'h0000_0100);
    @(negedge clk);
    chk_irq(1'b1, "R3");
    rd(3'd3, 32'h0000_7777, "R8");
    rd(3'd0, 32'h0000_0D00, "R6");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule